// File: doc/BRIEF.md
# Binary Rate Multiplier

This block produces a programmable fraction of its input clock rate as a train of single-cycle enable pulses. A free-running binary counter of N bits steps once per enabled clock. Purely combinational select logic looks at which bit is the lowest set bit of the current count and, if the matching selector bit is set, requests a pulse. Over one full counter period of 2^N clocks the number of pulses equals the selector value. The pulses from each selector bit are interleaved with those of the others, not clustered at one end of the period.

The output is a registered, one-clock-wide strobe intended as a clock enable for downstream logic. The clock itself is never gated. A selector of 5 with N = 4 yields 5 pulses in every 16 clocks, which is 5/16 of the input rate. Control pins are plain level signals. There is no data stream and so no valid/ready handshake or back-pressure. The width N is a parameter with a default of 4.

Top module: `pulse_rate_mult`

## Requirements
- R1: While `rst` is high at a rising edge, the counter is set to 0 and `tick` is low in the following cycle.
- R2: With `en` held high, the counter advances by one on every edge and wraps modulo 2^N, so the `tick` pattern for a fixed selector repeats every 2^N clocks.
- R3: Starting from count 0 with `en` high and `sel` fixed, exactly `sel` (read as an unsigned binary number) pulses appear on `tick` in the next 2^N clocks.
- R4: A count whose lowest set bit is at position k requests a pulse exactly when `sel[N-1-k]` is 1; count 0 never requests a pulse.
- R5: `tick` is registered: the pulse for the count held before a rising edge appears in the cycle after that edge and lasts exactly one clock.
- R6: While `en` is low, the counter holds its value and `tick` is low in the following cycle.
- R7: A new `sel` value applies to the count evaluated at the very next rising edge.
- R8: With `sel` all ones there are 2^N-1 pulses per period; with `sel` zero there are none.
- R9: With only `sel[N-1]` set, pulses fall on every odd count, so consecutive pulses are exactly two clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes the counter and silences `tick` |
| sel | input | N | Pulses per counter period |
| tick | output | 1 | One-clock enable strobe |

## Verification
Every result of this block is due one edge after the inputs that cause it: the count and selector present before an edge decide `tick` in the cycle after that edge. The bench drives inputs on the falling edge, keeps its own counter model, and compares `tick` at the next falling edge against the value its lowest-set-bit function predicts for the pre-edge count. Per-period totals are taken over the 2^N strobes that follow a reset, so each window begins at count 0.

// File: rtl/brm_pkg.sv
package brm_pkg;
  // Default counter width for the rate multiplier
  localparam int unsigned BRM_DEFAULT_W = 4;
endpackage

// File: rtl/brm_counter.sv
module brm_counter #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [N-1:0] count
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)     count <= '0;
    else if (en) count <= count + ONE;
  end
endmodule

// File: rtl/brm_select.sv
module brm_select #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] count,
  input  logic [N-1:0] sel,
  output logic         hit
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] lowbit;   // one-hot lowest set bit of count, zero for count 0
  logic [N-1:0] rsel;     // selector reversed: rsel[k] weights lowest-bit position k

  assign lowbit = count & (~count + ONE);

  for (genvar k = 0; k < N; k++) begin : g_rev
    assign rsel[k] = sel[N-1-k];
  end

  assign hit = |(lowbit & rsel);
endmodule

// File: rtl/brm_out_reg.sv
module brm_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hit,
  output logic tick
);
  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= en & hit;
  end
endmodule

// File: rtl/pulse_rate_mult.sv
module pulse_rate_mult #(
  parameter int unsigned N = brm_pkg::BRM_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] sel,
  output logic         tick
);
  logic [N-1:0] count;
  logic         hit;

  brm_counter #(.N(N)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .count (count)
  );

  brm_select #(.N(N)) u_sel (
    .count (count),
    .sel   (sel),
    .hit   (hit)
  );

  brm_out_reg u_out (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .hit  (hit),
    .tick (tick)
  );
endmodule

// File: rtl/pulse_rate_mult_chk.sv
module pulse_rate_mult_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [N-1:0] sel,
  input logic [N-1:0] count,
  input logic         tick
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  // R1: the cycle after a reset edge has no strobe
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tick);

  // R2: counter steps by one when enabled
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    en |=> count == $past(count) + ONE);

  // R6: counter frozen and strobe silent while disabled
  a_r6_hold_count: assert property (@(posedge clk) disable iff (rst)
    !en |=> count == $past(count));
  a_r6_no_tick: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);

  // R4: count zero never strobes
  a_r4_zero_silent: assert property (@(posedge clk) disable iff (rst)
    (en && count == '0) |=> !tick);

  // R9: odd counts strobe when the top selector bit is set
  a_r9_odd_fires: assert property (@(posedge clk) disable iff (rst)
    (en && count[0] && sel[N-1]) |=> tick);

  // R8: zero selector never strobes
  a_r8_zero_sel: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |=> !tick);
endmodule

bind pulse_rate_mult pulse_rate_mult_chk #(.N(N)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .sel   (sel),
  .count (count),
  .tick  (tick)
);

// File: tb/pulse_rate_mult_bench.sv
`timescale 1ns/1ps
module pulse_rate_mult_bench;
  localparam int unsigned N = 4;
  localparam int unsigned P = 1 << N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [N-1:0] sel = '0;
  logic         tick;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  int unsigned mcnt = 0;       // bench counter model
  logic [N-1:0] prev_sel = '0;

  always #10 clk = ~clk;       // 50 MHz

  pulse_rate_mult #(.N(N)) u_pulse_rate_mult (
    .clk (clk), .rst (rst), .en (en), .sel (sel), .tick (tick)
  );

  // Expected strobe request for a count: R4 rule
  function automatic logic want(input int unsigned c, input logic [N-1:0] s);
    if (c == 0) return 1'b0;
    for (int k = 0; k < N; k++)
      if (c[k]) return s[N-1-k];
    return 1'b0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: drive at falling edge, check strobe at the next falling edge
  task automatic step(input logic r, input logic e, input logic [N-1:0] s,
                      output logic got);
    logic exp;
    string tag;
    rst = r; en = e; sel = s;
    if (r) begin exp = 1'b0; tag = "R1"; mcnt = 0; end
    else if (!e) begin exp = 1'b0; tag = "R6"; end
    else begin
      exp = want(mcnt, s);
      tag = (s != prev_sel) ? "R7" : "R4 R5";
      mcnt = (mcnt + 1) % P;
    end
    prev_sel = s;
    @(posedge clk);
    @(negedge clk);
    got = tick;
    check(tag, int'(tick), int'(exp));
  endtask

  // Reset, then one full period from count 0; returns strobe pattern
  task automatic period(input logic [N-1:0] s, output logic [P-1:0] pat);
    logic g;
    step(1'b1, 1'b0, s, g);
    for (int i = 0; i < int'(P); i++) begin
      step(1'b0, 1'b1, s, g);
      pat[i] = g;
    end
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    logic [P-1:0] pat, pat2;
    logic g;
    @(negedge clk);
    step(1'b1, 1'b0, '0, g);
    check("R1 reset", int'(tick), 0);

    // R3: every selector value over a period from count 0
    for (int v = 0; v < int'(P); v++) begin
      period(N'(v), pat);
      check("R3 pulses per period", $countones(pat), v);
    end

    // R8 extremes
    period('1, pat);
    check("R8 all ones", $countones(pat), int'(P) - 1);
    period('0, pat);
    check("R8 zero", $countones(pat), 0);

    // 5 of 16 for selector 0101
    period(N'(5), pat);
    check("R3 five of sixteen", $countones(pat), 5);

    // R9: top bit alone strobes on odd counts
    period({1'b1, {(N-1){1'b0}}}, pat);
    check("R9 odd counts", int'(pat), int'(16'hAAAA));

    // R2: second period repeats the first
    period(N'(11), pat);
    for (int i = 0; i < int'(P); i++) begin
      step(1'b0, 1'b1, N'(11), g);
      pat2[i] = g;
    end
    check("R2 repeat", int'(pat2), int'(pat));

    // R6: hold mid-period, then resume without losing position
    period(N'(6), pat);
    step(1'b1, 1'b0, N'(15), g);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, N'(15), g);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, N'(15), g);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, N'(15), g);

    // Constrained random mix, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      logic r, e;
      logic [N-1:0] s;
      r = ($urandom % 64) == 0;
      e = ($urandom % 4) != 0;
      s = (($urandom % 8) == 0) ? N'($urandom) : sel;
      step(r, e, s, g);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule